// File: doc/BRIEF.md
# Multiple-Precision Serial Word Adder

This block adds two wide unsigned operands of `WORDS` x `WIDTH` bits using a single `WIDTH`-bit adder. The adder is reused once per clock. The operands arrive one word pair per cycle, lowest word first. A carry register links each word addition to the next. The register takes the carry-out of one word and feeds it back as the carry-in of the following word. Precision therefore depends on the word count and not on the adder width. One word gives single precision, two words give double precision.

A sequence opens with a one-cycle `start_i` pulse. That cycle carries no operand word. It loads `cin_i` into the carry register and clears the word counter. After that, each cycle with `word_vld_i` high is accepted as one word pair. The result word comes out one cycle later, flagged by `sum_vld_o`. The last result word also raises `done_o`.

`cout_o` shows the carry register at all times. After the last word it holds the final carry-out until the next start. A final carry of 1 means the unsigned sum does not fit in `WORDS` x `WIDTH` bits. Setting `cin_i` to 1 adds one extra unit, which is how a bit complement is turned into a two's complement.

Top module: `chain_word_adder`

## Requirements
- R1: While reset is active and directly after it, `sum_o`, `sum_vld_o`, `done_o` and `cout_o` are all 0.
- R2: The cycle after a `start_i` pulse, `cout_o` equals the `cin_i` value that was sampled with the pulse. A start cycle produces no result word.
- R3: A word pair accepted at a clock edge gives, one cycle later, `sum_vld_o` = 1 and `sum_o` = (`opa_i` + `opb_i` + carry register) mod 2^`WIDTH`.
- R4: After each accepted word, `cout_o` equals the carry-out of that word addition, and that carry is used as the carry-in of the next word.
- R5: The `WORDS` result words, placed lowest word at the lowest bit positions, equal (A + B + `cin_i`) mod 2^(`WIDTH`x`WORDS`). The final `cout_o` equals bit `WIDTH`x`WORDS` of the full sum, which marks unsigned overflow.
- R6: `done_o` is 1 for exactly one cycle, together with the `WORDS`-th result word, and never with any other word.
- R7: A cycle with `word_vld_i` low and no start leaves the carry register and the word count unchanged and produces no result. Idle gaps between words do not change the final result.
- R8: Words presented when no sequence is open are ignored: no `sum_vld_o`, no `done_o`, and `cout_o` stays the same. This covers words before the first start and words after the last word.
- R9: A `start_i` pulse in the middle of a sequence abandons that sequence. The new sequence then completes after exactly `WORDS` further accepted words.
- R10: `cin_i` = 1 adds exactly one to the full-width sum, including when that one carries through every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a sequence and loads the initial carry |
| cin_i | input | 1 | Initial carry-in, sampled with `start_i` |
| word_vld_i | input | 1 | Operand word pair valid |
| opa_i | input | WIDTH | Word of operand A |
| opb_i | input | WIDTH | Word of operand B |
| sum_o | output | WIDTH | Result word |
| sum_vld_o | output | 1 | Result word valid |
| done_o | output | 1 | High with the last result word |
| cout_o | output | 1 | Carry register; final carry-out after the last word |

## Verification
The bench uses a 4-bit, two-word configuration. Every value of operand A is combined with sixteen values of B spread over the full range, and each pair is run with both carry-in values. Pairs such as 0xFF + 0x00 with carry-in 1 and 0xFF + 0xFF separate a correctly chained carry from a carry that is dropped or stuck. The same pairs with carry-in 0 separate those cases from a carry-in that is ignored. Some vectors insert idle cycles between words or present extra words after completion; this shows whether the counter and carry hold their state. One sequence is restarted halfway through, to show that the counter clears and the carry reloads.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  // Width of a counter able to hold indices 0 .. words-1 (minimum one bit).
  function automatic int unsigned idx_width(input int unsigned words);
    idx_width = (words > 1) ? $clog2(words) : 1;
  endfunction

endpackage

// File: rtl/cwa_rst_sync.sv
module cwa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/cwa_word_add.sv
module cwa_word_add #(
  parameter int unsigned WIDTH  = 32,
  parameter bit          RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);

  generate
    if (RIPPLE) begin : g_ripple
      // Explicit bit-serial carry chain.
      always_comb begin
        logic carry;
        carry = c_i;
        for (int i = 0; i < int'(WIDTH); i++) begin
          s_o[i] = a_i[i] ^ b_i[i] ^ carry;
          carry  = (a_i[i] & b_i[i]) | (carry & (a_i[i] ^ b_i[i]));
        end
        c_o = carry;
      end
    end else begin : g_infer
      // Let synthesis pick the carry structure.
      logic [WIDTH:0] total;
      always_comb begin
        total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
        s_o   = total[WIDTH-1:0];
        c_o   = total[WIDTH];
      end
    end
  endgenerate

endmodule

// File: rtl/cwa_seq.sv
module cwa_seq #(
  parameter int unsigned WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic word_vld_i,
  output logic accept_o,
  output logic last_o
);

  import cwa_pkg::*;

  localparam int unsigned          CW       = idx_width(WORDS);
  localparam logic [CW-1:0]        LAST_IDX = CW'(WORDS - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] idx_q, idx_d;

  assign accept_o = busy_q & word_vld_i & ~start_i;
  assign last_o   = accept_o & (idx_q == LAST_IDX);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (start_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (accept_o) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && idx_q == '0)); // R9

  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !word_vld_i) |=> ($stable(idx_q) && $stable(busy_q))); // R7

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !busy_q); // R6

endmodule

// File: rtl/chain_word_adder.sv
module chain_word_adder #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned WORDS  = 2,
  parameter bit          RIPPLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cin_i,
  input  logic             word_vld_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             sum_vld_o,
  output logic             done_o,
  output logic             cout_o
);

  logic             rst_n_int;
  logic             accept, last;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;

  logic             carry_q, carry_d;
  logic [WIDTH-1:0] sum_q, sum_d;
  logic             svld_q, svld_d;
  logic             done_q, done_d;

  cwa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cwa_seq #(.WORDS(WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (start_i),
    .word_vld_i (word_vld_i),
    .accept_o   (accept),
    .last_o     (last)
  );

  cwa_word_add #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
    .a_i (opa_i),
    .b_i (opb_i),
    .c_i (carry_q),
    .s_o (add_sum),
    .c_o (add_cout)
  );

  always_comb begin
    carry_d = carry_q;
    sum_d   = sum_q;
    svld_d  = 1'b0;
    done_d  = 1'b0;
    if (start_i) begin
      carry_d = cin_i;
    end else if (accept) begin
      carry_d = add_cout;
      sum_d   = add_sum;
      svld_d  = 1'b1;
      done_d  = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      carry_q <= 1'b0;
      sum_q   <= '0;
      svld_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      carry_q <= carry_d;
      sum_q   <= sum_d;
      svld_q  <= svld_d;
      done_q  <= done_d;
    end
  end

  assign sum_o     = sum_q;
  assign sum_vld_o = svld_q;
  assign done_o    = done_q;
  assign cout_o    = carry_q;

  AST_START_LOADS_CARRY: assert property (@(posedge clk) disable iff (!rst_n_int)
    start_i |=> (cout_o == $past(cin_i) && !sum_vld_o)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_o |=> !done_o); // R6

  AST_DONE_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_o |-> sum_vld_o); // R6

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!start_i && !word_vld_i) |=> (!sum_vld_o && $stable(cout_o))); // R7

  AST_WORD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_int)
    (word_vld_i && !start_i) |=> (sum_vld_o || $stable(cout_o))); // R8

  always_comb begin
    if (!rst_n_int) begin
      AST_RESET_QUIET: assert (!sum_vld_o && !done_o && !cout_o && sum_o == '0); // R1
    end
  end

endmodule

// File: tb/sim_chain_word_adder.sv
module sim_chain_word_adder;

  localparam int unsigned BN = 4;
  localparam int unsigned BK = 2;
  localparam int unsigned TW = BN * BK;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cin_i = 1'b0;
  logic          word_vld_i = 1'b0;
  logic [BN-1:0] opa_i = '0;
  logic [BN-1:0] opb_i = '0;
  logic [BN-1:0] sum_o;
  logic          sum_vld_o, done_o, cout_o;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  chain_word_adder #(.WIDTH(BN), .WORDS(BK), .RIPPLE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cin_i(cin_i),
    .word_vld_i(word_vld_i), .opa_i(opa_i), .opb_i(opb_i),
    .sum_o(sum_o), .sum_vld_o(sum_vld_o), .done_o(done_o), .cout_o(cout_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // Reference: sum of the low w words of a and b plus cin, full width.
  function automatic longint part_sum(input longint a, input longint b,
                                      input bit c, input int w);
    longint m;
    m = (longint'(1) << (w * BN)) - 1;
    return (a & m) + (b & m) + longint'(c);
  endfunction

  task automatic run_op(input longint a, input longint b, input bit c,
                        input bit gaps, input bit stray);
    longint full;
    bit     fin;
    full = longint'(a) + longint'(b) + longint'(c);
    @(negedge clk);
    start_i = 1'b1; cin_i = c;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 carry loaded", longint'(cout_o), longint'(c));
    for (int w = 0; w < int'(BK); w++) begin
      word_vld_i = 1'b1;
      opa_i = BN'(a >> (w * BN));
      opb_i = BN'(b >> (w * BN));
      @(negedge clk);
      word_vld_i = 1'b0;
      check("R3 word valid", longint'(sum_vld_o), 1);
      check("R5 sum word", longint'(sum_o), (full >> (w * BN)) & ((1 << BN) - 1));
      check("R4 chained carry", longint'(cout_o),
            (part_sum(a, b, c, w + 1) >> ((w + 1) * BN)) & 1);
      check("R6 done position", longint'(done_o), (w == int'(BK) - 1) ? 1 : 0);
      if (gaps && w != int'(BK) - 1) begin
        @(negedge clk);
        check("R7 gap no word", longint'(sum_vld_o), 0);
        check("R7 gap carry held", longint'(cout_o),
              (part_sum(a, b, c, w + 1) >> ((w + 1) * BN)) & 1);
      end
    end
    fin = bit'((full >> TW) & 1);
    check("R5 final carry", longint'(cout_o), longint'(fin));
    if (stray) begin
      word_vld_i = 1'b1; opa_i = '1; opb_i = '1;
      @(negedge clk);
      word_vld_i = 1'b0;
      check("R8 stray word ignored", longint'(sum_vld_o), 0);
      check("R8 stray no done", longint'(done_o), 0);
      check("R8 carry held", longint'(cout_o), longint'(fin));
    end else begin
      @(negedge clk);
      check("R6 done one cycle", longint'(done_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sum", longint'(sum_o), 0);
    check("R1 reset flags", longint'({sum_vld_o, done_o, cout_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", longint'({sum_vld_o, done_o, cout_o}), 0);
    // R8: words before any start are ignored.
    word_vld_i = 1'b1; opa_i = '1; opb_i = '1;
    @(negedge clk);
    word_vld_i = 1'b0;
    check("R8 pre-start ignored", longint'({sum_vld_o, cout_o}), 0);

    // R10: +1 carried through every word.
    run_op(longint'((1 << TW) - 1), 0, 1'b1, 1'b0, 1'b0);
    check("R10 wrap to zero", longint'(cout_o), 1);

    // R9: restart halfway through a sequence.
    @(negedge clk);
    start_i = 1'b1; cin_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    word_vld_i = 1'b1; opa_i = BN'(15); opb_i = BN'(15);
    @(negedge clk);
    word_vld_i = 1'b0;
    check("R9 first word before restart", longint'(done_o), 0);
    run_op(longint'(8'h3C), longint'(8'h5A), 1'b0, 1'b0, 1'b0);
    check("R9 restarted result carry", longint'(cout_o), 0);

    // Sweep: every A, sixteen spread B values, both carry-ins.
    for (int ai = 0; ai < (1 << TW); ai++) begin
      for (int bj = 0; bj < 16; bj++) begin
        for (int ci = 0; ci < 2; ci++) begin
          run_op(longint'(ai), longint'(bj * 17), bit'(ci),
                 (ai % 7) == 0, (ai % 5) == 0);
        end
      end
    end
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

endmodule